// File: doc/BRIEF.md
# Peripheral Bus Transfer Phase Monitor

This block is a passive observer attached to the bus wires of one APB subordinate. It drives nothing onto the bus. From select, enable and ready it tracks which phase the bus is in: idle, the single presentation cycle (select high, enable low), or the access cycles that follow it. On the presentation cycle it stores the address, the direction bit and the write data. On every later access cycle, up to and including the cycle where ready is sampled high, it compares the live bus against the stored copy.

Five kinds of rule breach are detected:
- a presentation cycle that repeats;
- a presentation cycle that is not followed by an access;
- a change of the presented values while the transfer is still open;
- an enable with no presentation cycle before it;
- a transfer abandoned during a wait state.

Each kind has its own one-cycle pulse and its own sticky flag, which only reset clears. A separate pulse marks every transfer that completes legally. All outputs are registered, so each one reports the bus cycle sampled on the previous clock edge.

Top module: `apb_phase_monitor`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, every bit of errPulse and errSticky and also donePulse are 0.
- R2: A cycle where busSel, busEnable and busReady are all high, which follows a presentation cycle or a wait cycle and whose compared values match, makes donePulse high for exactly the next cycle. No other cycle makes donePulse high.
- R3: A presentation cycle (busSel=1, busEnable=0) directly after another presentation cycle raises errPulse bit 0. Its values replace the stored copy, so the transfer then continues normally.
- R4: A presentation cycle followed by a cycle with busSel low raises errPulse bit 1.
- R5: An access cycle whose busAddr or busWrite differs from the values stored at presentation raises errPulse bit 2. busWdata is also compared, but only when busWrite was 1 at presentation, so a read ignores changes in write data. A completion cycle that raises bit 2 gives no donePulse.
- R6: busSel and busEnable both high while no transfer is open raises errPulse bit 3. No transfer is open either from idle or on the cycle right after a completion.
- R7: After an access cycle with busReady low, a cycle where busSel or busEnable is low raises errPulse bit 4.
- R8: Each errPulse bit is high for one cycle per offending bus cycle. The matching errSticky bit is set at the same time and stays set until reset.
- R9: Every output reflects the bus cycle sampled at the previous rising clock edge (one register of latency).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Subordinate select as seen on the bus |
| busEnable | input | 1 | Access-phase enable as seen on the bus |
| busReady | input | 1 | Subordinate ready as seen on the bus |
| busAddr | input | ADDR_W | Transfer address |
| busWrite | input | 1 | Direction, 1 = write |
| busWdata | input | DATA_W | Write data |
| errPulse | output | 5 | One-cycle violation pulses: bit 0 repeated presentation, 1 missing access, 2 unstable values, 3 enable without presentation, 4 abandoned wait |
| errSticky | output | 5 | Sticky copies of errPulse, same bit order |
| donePulse | output | 1 | One-cycle pulse per legal completion |

## Verification
Legal transfers are run both as zero-wait writes and as reads with two wait states in which the write data wanders. This separates a correct completion from one that wrongly flags write data the read does not care about. Unstable-value cases change the address, the direction bit and the write data one at a time. Each is changed on a different access cycle (on a wait cycle as well as on the completing cycle), which shows that the comparison covers every open cycle and that the completion pulse is suppressed. Each remaining breach is then produced alone, followed by a run of several breaches without reset in between. Together they show that each pulse lands only on its own bit, that the sticky flags accumulate, and that reset clears them.

// File: rtl/apb_mon_pkg.sv
package apb_mon_pkg;
  localparam int NUM_ERR = 5;
  localparam int ERR_REPEAT_SETUP = 0;
  localparam int ERR_MISSED_ACCESS = 1;
  localparam int ERR_UNSTABLE = 2;
  localparam int ERR_ORPHAN_ENABLE = 3;
  localparam int ERR_ABORT = 4;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_WAIT  = 2'd2
  } phase_t;

  typedef struct packed {
    logic               capture;
    logic [NUM_ERR-1:0] viol;
    logic               done;
  } ctrlStrobe_t;
endpackage

// File: rtl/apb_mon_ctrl.sv
module apb_mon_ctrl
  import apb_mon_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        busSel,
  input  logic        busEnable,
  input  logic        busReady,
  input  logic        mismatch,
  output ctrlStrobe_t strobe
);
  phase_t phase, nextPhase;

  logic presentCyc, accessCyc;
  assign presentCyc = busSel && !busEnable;
  assign accessCyc  = busSel && busEnable;

  always_comb begin
    strobe    = '0;
    nextPhase = phase;
    unique case (phase)
      PH_IDLE: begin
        if (presentCyc) begin
          strobe.capture = 1'b1;
          nextPhase      = PH_SETUP;
        end else if (accessCyc) begin
          strobe.viol[ERR_ORPHAN_ENABLE] = 1'b1;
          nextPhase                      = PH_IDLE;
        end
      end
      PH_SETUP, PH_WAIT: begin
        if (accessCyc) begin
          strobe.viol[ERR_UNSTABLE] = mismatch;
          if (busReady) begin
            strobe.done = !mismatch;
            nextPhase   = PH_IDLE;
          end else begin
            nextPhase = PH_WAIT;
          end
        end else begin
          if (phase == PH_SETUP) begin
            if (presentCyc) strobe.viol[ERR_REPEAT_SETUP] = 1'b1;
            else            strobe.viol[ERR_MISSED_ACCESS] = 1'b1;
          end else begin
            strobe.viol[ERR_ABORT] = 1'b1;
          end
          if (presentCyc) begin
            strobe.capture = 1'b1;
            nextPhase      = PH_SETUP;
          end else begin
            nextPhase = PH_IDLE;
          end
        end
      end
      default: nextPhase = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= nextPhase;
  end
endmodule

// File: rtl/apb_mon_datapath.sv
module apb_mon_datapath
  import apb_mon_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWrite,
  input  logic [DATA_W-1:0]  busWdata,
  input  ctrlStrobe_t        strobe,
  output logic               mismatch,
  output logic [NUM_ERR-1:0] errPulse,
  output logic [NUM_ERR-1:0] errSticky,
  output logic               donePulse
);
  logic [ADDR_W-1:0] capAddr;
  logic              capWrite;
  logic [DATA_W-1:0] capWdata;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capAddr  <= '0;
      capWrite <= 1'b0;
      capWdata <= '0;
    end else if (strobe.capture) begin
      capAddr  <= busAddr;
      capWrite <= busWrite;
      capWdata <= busWdata;
    end
  end

  logic addrDiff, dirDiff, dataDiff;
  assign addrDiff = busAddr != capAddr;
  assign dirDiff  = busWrite != capWrite;
  assign dataDiff = capWrite && (busWdata != capWdata);
  assign mismatch = addrDiff || dirDiff || dataDiff;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errPulse  <= '0;
      donePulse <= 1'b0;
    end else begin
      errPulse  <= strobe.viol;
      donePulse <= strobe.done;
    end
  end

  for (genvar i = 0; i < NUM_ERR; i++) begin : g_sticky
    always_ff @(posedge clk) begin
      if (!rstN)              errSticky[i] <= 1'b0;
      else if (strobe.viol[i]) errSticky[i] <= 1'b1;
    end
  end
endmodule

// File: rtl/apb_phase_monitor.sv
module apb_phase_monitor
  import apb_mon_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busEnable,
  input  logic              busReady,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic [DATA_W-1:0] busWdata,
  output logic [4:0]        errPulse,
  output logic [4:0]        errSticky,
  output logic              donePulse
);
  ctrlStrobe_t strobe;
  logic        mismatch;

  apb_mon_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busSel    (busSel),
    .busEnable (busEnable),
    .busReady  (busReady),
    .mismatch  (mismatch),
    .strobe    (strobe)
  );

  apb_mon_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .busAddr   (busAddr),
    .busWrite  (busWrite),
    .busWdata  (busWdata),
    .strobe    (strobe),
    .mismatch  (mismatch),
    .errPulse  (errPulse),
    .errSticky (errSticky),
    .donePulse (donePulse)
  );
endmodule

// File: rtl/apb_phase_monitor_chk.sv
module apb_phase_monitor_chk (
  input logic       clk,
  input logic       rstN,
  input logic       busSel,
  input logic       busEnable,
  input logic       busReady,
  input logic [4:0] errPulse,
  input logic [4:0] errSticky,
  input logic       donePulse
);
  // R8
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (($past(errSticky) & ~errSticky) == 5'b0));

  // R8
  pulse_sets_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((errPulse & ~errSticky) == 5'b0));

  // R2
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);

  // R2
  done_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> $past(busSel && busEnable && busReady));

  // R3
  repeat_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    errPulse[0] |-> $past(busSel && !busEnable));

  // R4
  missed_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    errPulse[1] |-> $past(!busSel));

  // R6
  orphan_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    errPulse[3] |-> $past(busSel && busEnable));
endmodule

bind apb_phase_monitor apb_phase_monitor_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busSel    (busSel),
  .busEnable (busEnable),
  .busReady  (busReady),
  .errPulse  (errPulse),
  .errSticky (errSticky),
  .donePulse (donePulse)
);

// File: tb/apb_phase_monitor_tb.sv
module apb_phase_monitor_tb;
  localparam int AW = 12;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rstN;
  logic          busSel, busEnable, busReady, busWrite;
  logic [AW-1:0] busAddr;
  logic [DW-1:0] busWdata;
  logic [4:0]    errPulse, errSticky;
  logic          donePulse;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  apb_phase_monitor #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busEnable(busEnable),
    .busReady(busReady), .busAddr(busAddr), .busWrite(busWrite),
    .busWdata(busWdata), .errPulse(errPulse), .errSticky(errSticky),
    .donePulse(donePulse)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one bus cycle at a falling edge, return at the next falling edge
  task automatic cyc(input logic s, input logic e, input logic r,
                     input logic [AW-1:0] a, input logic w, input logic [DW-1:0] d);
    busSel = s; busEnable = e; busReady = r;
    busAddr = a; busWrite = w; busWdata = d;
    @(negedge clk);
  endtask

  task automatic idle();
    cyc(0, 0, 0, '0, 0, '0);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    busSel = 0; busEnable = 0; busReady = 0; busAddr = '0; busWrite = 0; busWdata = '0;
    repeat (2) @(negedge clk);
    chk("R1 pulses in reset", {26'b0, errPulse, donePulse}, 0);
    chk("R1 sticky in reset", errSticky, 0);
    rstN = 1'b1;
  endtask

  task automatic t_reset();
    doReset();
    idle();
    chk("R1 after release", {21'b0, errSticky, errPulse, donePulse}, 0);
  endtask

  task automatic t_legalWrite();
    doReset();
    idle();
    cyc(1, 0, 0, 12'h040, 1, 32'hDEAD_BEEF);
    chk("R9 no done during setup", donePulse, 0);
    cyc(1, 1, 1, 12'h040, 1, 32'hDEAD_BEEF);
    chk("R2 done after zero-wait write", donePulse, 1);
    chk("R2 no error on legal write", errPulse, 0);
    idle();
    chk("R2 done lasts one cycle", donePulse, 0);
    chk("R2 sticky clean", errSticky, 0);
  endtask

  task automatic t_readWaits();
    doReset();
    cyc(1, 0, 0, 12'h100, 0, 32'h1);
    cyc(1, 1, 0, 12'h100, 0, 32'h2);
    cyc(1, 1, 0, 12'h100, 0, 32'h3);
    chk("R5 read ignores wdata in wait", errPulse, 0);
    chk("R2 no done in wait", donePulse, 0);
    cyc(1, 1, 1, 12'h100, 0, 32'h4);
    chk("R2 done after waited read", donePulse, 1);
    chk("R5 read ignores wdata at completion", errPulse, 0);
  endtask

  task automatic t_wdataChange();
    doReset();
    cyc(1, 0, 0, 12'h010, 1, 32'hAAAA_0000);
    cyc(1, 1, 0, 12'h010, 1, 32'hAAAA_0000);
    chk("R5 stable wait no flag", errPulse, 0);
    cyc(1, 1, 0, 12'h010, 1, 32'hAAAA_0001);
    chk("R5 wdata change in wait", errPulse, 5'b00100);
    cyc(1, 1, 1, 12'h010, 1, 32'hAAAA_0001);
    chk("R5 wdata change at completion", errPulse, 5'b00100);
    chk("R5 no done on bad completion", donePulse, 0);
    idle();
    chk("R8 pulse drops", errPulse, 0);
    chk("R8 sticky holds unstable", errSticky, 5'b00100);
  endtask

  task automatic t_addrDirChange();
    doReset();
    cyc(1, 0, 0, 12'h200, 0, '0);
    cyc(1, 1, 1, 12'h204, 0, '0);
    chk("R5 addr change", errPulse, 5'b00100);
    chk("R5 addr change no done", donePulse, 0);
    doReset();
    cyc(1, 0, 0, 12'h300, 1, 32'h5);
    cyc(1, 1, 0, 12'h300, 0, 32'h5);
    chk("R5 direction change", errPulse, 5'b00100);
  endtask

  task automatic t_repeatSetup();
    doReset();
    cyc(1, 0, 0, 12'h020, 1, 32'h11);
    cyc(1, 0, 0, 12'h024, 1, 32'h22);
    chk("R3 repeated setup", errPulse, 5'b00001);
    cyc(1, 1, 1, 12'h024, 1, 32'h22);
    chk("R3 second copy used", errPulse, 0);
    chk("R3 completes after recapture", donePulse, 1);
    chk("R3 sticky", errSticky, 5'b00001);
  endtask

  task automatic t_missedAccess();
    doReset();
    cyc(1, 0, 0, 12'h030, 0, '0);
    idle();
    chk("R4 setup then idle", errPulse, 5'b00010);
  endtask

  task automatic t_orphan();
    doReset();
    idle();
    cyc(1, 1, 1, 12'h050, 0, '0);
    chk("R6 enable from idle", errPulse, 5'b01000);
    chk("R6 no done", donePulse, 0);
    doReset();
    cyc(1, 0, 0, 12'h054, 0, '0);
    cyc(1, 1, 1, 12'h054, 0, '0);
    chk("R2 completion before back-to-back", donePulse, 1);
    cyc(1, 1, 1, 12'h054, 0, '0);
    chk("R6 access right after completion", errPulse, 5'b01000);
  endtask

  task automatic t_abort();
    doReset();
    cyc(1, 0, 0, 12'h060, 1, 32'h9);
    cyc(1, 1, 0, 12'h060, 1, 32'h9);
    idle();
    chk("R7 select dropped in wait", errPulse, 5'b10000);
    doReset();
    cyc(1, 0, 0, 12'h064, 1, 32'h9);
    cyc(1, 1, 0, 12'h064, 1, 32'h9);
    cyc(1, 0, 0, 12'h064, 1, 32'h9);
    chk("R7 enable dropped in wait", errPulse, 5'b10000);
  endtask

  task automatic t_accumulate();
    doReset();
    cyc(1, 0, 0, 12'h070, 0, '0);
    idle();
    cyc(1, 1, 1, 12'h070, 0, '0);
    cyc(1, 0, 0, 12'h070, 0, '0);
    cyc(1, 0, 0, 12'h070, 0, '0);
    idle();
    chk("R8 sticky accumulates", errSticky, 5'b01011);
    doReset();
    idle();
    chk("R1 reset clears sticky", errSticky, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_legalWrite();
    t_readWaits();
    t_wdataChange();
    t_addrDirChange();
    t_repeatSetup();
    t_missedAccess();
    t_orphan();
    t_abort();
    t_accumulate();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule